// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a multi-channel event timer. It watches a shared main counter that lives outside it. It holds a 64-bit comparator, a hidden period register and a per-channel configuration word. When the counter reaches the comparator, the channel emits a one-cycle interrupt pulse on one of several output lines.

A channel runs in one of two modes:
- **One-shot:** the channel fires when the counter matches the comparator.
- **Periodic:** each match advances the comparator by the period. If the comparator has fallen behind the counter, the channel keeps advancing it until it is ahead again.

A 32-bit compatibility mode limits both the comparison and the arithmetic to the low word. When this mode is combined with one-shot, the channel also fires once when the counter's low word wraps to zero.

Software reaches the channel through three 32-bit write strobes: configuration, comparator low half and comparator high half. A set-value bit in the configuration lets software load the comparator while the channel is in periodic mode. Routing normally comes from a field in the configuration. When the legacy routing input is high, channel 0 is forced onto line 0 and channel 1 onto line 8.

Top module: `evtmr_channel`

## Requirements
- R1: After reset, `cfg_word` reads 0x0000_0004_0000_0030, `cmp_word` reads all ones, the period is zero, and `irq_lines` and `cfg_err` are 0.
- R2: A config write stores these bits of `wr_data`:
  - bit 2: channel enable
  - bit 3: periodic
  - bit 6: set-value
  - bit 8: 32-bit mode
  - bits 13:9: route line

  Bits 4 and 5 (periodic-capable, 64-bit-capable) and bit 34 (route line 2 available) always read 1. All other bits read 0.
- R3: A config write with bit 1 (level trigger) set pulses `cfg_err` for one cycle, visible together with the config update. The bit is never stored.
- R4: A config write with bit 8 set clears the upper 32 bits of the comparator and of the period.
- R5: A comparator half write changes that half of the comparator only when the channel is one-shot or set-value is set. Any comparator half write clears set-value.
- R6: In periodic mode, a low-half write loads period[31:0]. In 32-bit mode, period bit 31 is forced to 0. A periodic high-half write that does not update the comparator loads period[62:32] with bit 63 forced to 0 in 64-bit mode, and is ignored in 32-bit mode.
- R7: A match is a cycle with `cnt_tick` and `glb_en` high where the counter equals the comparator: over the low word in 32-bit mode, over all 64 bits otherwise. A match on an enabled channel drives a single-cycle pulse on `irq_lines` in the following cycle.
- R8: In periodic mode with a nonzero period, a match adds the period to the comparator. In 32-bit mode the addition is modulo 2^32 on the low word.
- R9: After a periodic match, the channel adds one period per cycle while the comparator is behind the counter (negative signed difference in the selected width), then stops. No interrupt is raised while it catches up.
- R10: In 32-bit one-shot mode, the first tick after a config or comparator write whose counter low word is zero raises an interrupt, unless a match happened first. Later wraps raise nothing until the next such write.
- R11: With `legacy_rt` high, channel index 0 fires on line 0 and index 1 on line 8. Otherwise the line is the route field.
- R12: No interrupt is produced while the channel enable or `glb_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | CW (64) | Main counter value |
| cnt_tick | input | 1 | Counter advanced to `cnt_val` this cycle |
| glb_en | input | 1 | Global enable |
| legacy_rt | input | 1 | Legacy routing override |
| wr_cfg | input | 1 | Config word write strobe |
| wr_cmp_lo | input | 1 | Comparator low half write strobe |
| wr_cmp_hi | input | 1 | Comparator high half write strobe |
| wr_data | input | CW/2 (32) | Write data |
| cfg_word | output | CW (64) | Current configuration word |
| cmp_word | output | CW (64) | Current comparator |
| irq_lines | output | LINES (32) | One-hot interrupt pulse |
| cfg_err | output | 1 | Level-trigger request flagged |

## Verification
The hardest state to reach is catch-up, where a periodic comparator trails a counter that has jumped far ahead. The hardware counter only steps by one, so this gap cannot occur in normal running. The bench drives the counter value directly: it produces a match, then moves the counter several periods forward without a tick, and follows the comparator one period per cycle. The 32-bit wrap interrupt is reached the same way, by presenting counter values whose low word is zero right after arming, with the upper word varying to show that it is ignored.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

    // Config bit positions. Software encodes these, so they are fixed.
    localparam int CFG_TRIG  = 1;
    localparam int CFG_EN    = 2;
    localparam int CFG_PER   = 3;
    localparam int CFG_PCAP  = 4;
    localparam int CFG_WCAP  = 5;
    localparam int CFG_SETV  = 6;
    localparam int CFG_M32   = 8;
    localparam int CFG_RT_LO = 9;
    localparam int CFG_RT_HI = 13;
    localparam int RTCAP_BIT = 34;
    localparam int RT_W      = CFG_RT_HI - CFG_RT_LO + 1;

    typedef struct packed {
        logic            en;
        logic            per;
        logic            setv;
        logic            m32;
        logic [RT_W-1:0] route;
    } chcfg_t;

    function automatic logic [63:0] pack_cfg(input chcfg_t c);
        logic [63:0] w;
        w                       = '0;
        w[CFG_EN]               = c.en;
        w[CFG_PER]              = c.per;
        w[CFG_PCAP]             = 1'b1;
        w[CFG_WCAP]             = 1'b1;
        w[CFG_SETV]             = c.setv;
        w[CFG_M32]              = c.m32;
        w[CFG_RT_HI:CFG_RT_LO]  = c.route;
        w[RTCAP_BIT]            = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/evtmr_match.sv
module evtmr_match #(
    parameter int CW = 64
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic          m32,
    input  logic          tick_ok,
    input  logic          wrap_ok,
    output logic          hit,
    output logic          wrap_hit,
    output logic          behind
);
    localparam int HW = CW / 2;

    logic [CW-1:0] diff_full;
    logic [HW-1:0] diff_lo;
    logic          eq_lo;
    logic          eq_full;

    always_comb begin
        eq_lo     = (cnt[HW-1:0] == cmp[HW-1:0]);
        eq_full   = (cnt == cmp);
        diff_full = cmp - cnt;
        diff_lo   = cmp[HW-1:0] - cnt[HW-1:0];
        hit       = tick_ok && (m32 ? eq_lo : eq_full);
        behind    = m32 ? diff_lo[HW-1] : diff_full[CW-1];
        wrap_hit  = tick_ok && wrap_ok && (cnt[HW-1:0] == '0) && !hit;
    end

endmodule

// File: rtl/evtmr_route.sv
module evtmr_route #(
    parameter int CH_INDEX = 0,
    parameter int LINES    = 32,
    parameter int RT_W     = 5
) (
    input  logic             fire,
    input  logic             legacy,
    input  logic [RT_W-1:0]  route,
    output logic [LINES-1:0] lines
);
    localparam int LEG_LINE0 = 0;
    localparam int LEG_LINE1 = 8;

    logic [RT_W-1:0] sel;

    generate
        if (CH_INDEX == 0) begin : g_leg0
            always_comb sel = legacy ? RT_W'(LEG_LINE0) : route;
        end else if (CH_INDEX == 1) begin : g_leg1
            always_comb sel = legacy ? RT_W'(LEG_LINE1) : route;
        end else begin : g_noleg
            always_comb sel = route;
        end
    endgenerate

    always_comb begin
        lines = '0;
        for (int i = 0; i < LINES; i++) begin
            if (fire && (sel == RT_W'(i))) lines[i] = 1'b1;
        end
    end

endmodule

// File: rtl/evtmr_channel.sv
module evtmr_channel
    import evtmr_pkg::*;
#(
    parameter int CH_INDEX = 0,
    parameter int LINES    = 32,
    parameter int CW       = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   cnt_val,
    input  logic            cnt_tick,
    input  logic            glb_en,
    input  logic            legacy_rt,
    input  logic            wr_cfg,
    input  logic            wr_cmp_lo,
    input  logic            wr_cmp_hi,
    input  logic [CW/2-1:0] wr_data,
    output logic [CW-1:0]   cfg_word,
    output logic [CW-1:0]   cmp_word,
    output logic [LINES-1:0] irq_lines,
    output logic            cfg_err
);
    localparam int HW = CW / 2;

    typedef struct packed {
        chcfg_t           cfg;
        logic [CW-1:0]    cmp;
        logic [CW-1:0]    period;
        logic             catchup;
        logic             arm;
        logic             err;
        logic [LINES-1:0] irq;
    } st_t;

    st_t st_q, st_d;

    logic             hit, wrap_hit, behind, per_nz, fire;
    logic [CW-1:0]    advanced;
    logic [LINES-1:0] line_sel;

    evtmr_match #(.CW(CW)) u_match (
        .cnt      (cnt_val),
        .cmp      (st_q.cmp),
        .m32      (st_q.cfg.m32),
        .tick_ok  (cnt_tick && glb_en),
        .wrap_ok  (st_q.arm && st_q.cfg.m32 && !st_q.cfg.per),
        .hit      (hit),
        .wrap_hit (wrap_hit),
        .behind   (behind)
    );

    evtmr_route #(.CH_INDEX(CH_INDEX), .LINES(LINES), .RT_W(RT_W)) u_route (
        .fire   (fire),
        .legacy (legacy_rt),
        .route  (st_q.cfg.route),
        .lines  (line_sel)
    );

    always_comb begin
        fire     = (hit || wrap_hit) && st_q.cfg.en;
        per_nz   = st_q.cfg.m32 ? (|st_q.period[HW-1:0]) : (|st_q.period);
        advanced = st_q.cmp + st_q.period;
        if (st_q.cfg.m32) begin
            advanced = {st_q.cmp[CW-1:HW], st_q.cmp[HW-1:0] + st_q.period[HW-1:0]};
        end

        st_d     = st_q;
        st_d.err = 1'b0;
        st_d.irq = line_sel;

        // Counter-driven events: match reload, catch-up, wrap disarm
        if (hit) begin
            if (st_q.cfg.per && per_nz) st_d.cmp = advanced;
            st_d.catchup = st_q.cfg.per && per_nz;
            st_d.arm     = 1'b0;
        end else if (st_q.catchup) begin
            if (behind && st_q.cfg.per && per_nz) st_d.cmp = advanced;
            else                                  st_d.catchup = 1'b0;
        end
        if (wrap_hit) st_d.arm = 1'b0;

        // Register writes take precedence over counter events
        if (wr_cfg) begin
            st_d.cfg.en    = wr_data[CFG_EN];
            st_d.cfg.per   = wr_data[CFG_PER];
            st_d.cfg.setv  = wr_data[CFG_SETV];
            st_d.cfg.m32   = wr_data[CFG_M32];
            st_d.cfg.route = wr_data[CFG_RT_HI:CFG_RT_LO];
            st_d.err       = wr_data[CFG_TRIG];
            st_d.arm       = 1'b1;
            if (wr_data[CFG_M32]) begin
                st_d.cmp[CW-1:HW]    = '0;
                st_d.period[CW-1:HW] = '0;
            end
        end

        if (wr_cmp_lo) begin
            if (!st_q.cfg.per || st_q.cfg.setv) st_d.cmp[HW-1:0] = wr_data;
            if (st_q.cfg.per) begin
                st_d.period[HW-1:0] = st_q.cfg.m32 ? {1'b0, wr_data[HW-2:0]} : wr_data;
            end
            st_d.cfg.setv = 1'b0;
            st_d.arm      = 1'b1;
            st_d.catchup  = 1'b0;
        end

        if (wr_cmp_hi) begin
            if (!st_q.cfg.per || st_q.cfg.setv) begin
                st_d.cmp[CW-1:HW] = wr_data;
            end else if (!st_q.cfg.m32) begin
                st_d.period[CW-1:HW] = {1'b0, wr_data[HW-2:0]};
            end
            st_d.cfg.setv = 1'b0;
            st_d.arm      = 1'b1;
            st_d.catchup  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg     <= '0;
            st_q.cmp     <= '1;
            st_q.period  <= '0;
            st_q.catchup <= 1'b0;
            st_q.arm     <= 1'b0;
            st_q.err     <= 1'b0;
            st_q.irq     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_word  = pack_cfg(st_q.cfg);
        cmp_word  = st_q.cmp;
        irq_lines = st_q.irq;
        cfg_err   = st_q.err;
    end

    // R11: at most one line pulses
    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_lines));

    // R12: a pulse needs both enables in the cycle before
    a_r12_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_lines) |-> ($past(glb_en) && $past(st_q.cfg.en)));

    // R7: a pulse follows a counter tick
    a_r7_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_lines) |-> $past(cnt_tick));

    // R5: set-value clears after a comparator half write
    a_r5_setv_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_cmp_lo || wr_cmp_hi) && !wr_cfg) |=> !st_q.cfg.setv);

    // R6: period top bit is always clear
    a_r6_period_msb: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.period[CW-1]);

    // R4: 32-bit mode keeps the period upper word clear
    a_r4_period_hi: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg.m32 |-> (st_q.period[CW-1:HW] == '0));

    // R3: the error flag only follows a config write
    a_r3_err_src: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(wr_cfg));

endmodule

// File: tb/evtmr_channel_bench.sv
module evtmr_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] cnt_val;
    logic        cnt_tick, glb_en, legacy_rt;
    logic        wr_cfg, wr_cmp_lo, wr_cmp_hi;
    logic [31:0] wr_data;
    logic [63:0] cfg_word, cmp_word, cfg_word1, cmp_word1;
    logic [31:0] irq_lines, irq_lines1;
    logic        cfg_err, cfg_err1;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    evtmr_channel u_evtmr_channel (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
        .glb_en(glb_en), .legacy_rt(legacy_rt), .wr_cfg(wr_cfg),
        .wr_cmp_lo(wr_cmp_lo), .wr_cmp_hi(wr_cmp_hi), .wr_data(wr_data),
        .cfg_word(cfg_word), .cmp_word(cmp_word), .irq_lines(irq_lines),
        .cfg_err(cfg_err));

    evtmr_channel #(.CH_INDEX(1)) u_evtmr_channel_ch1 (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
        .glb_en(glb_en), .legacy_rt(legacy_rt), .wr_cfg(wr_cfg),
        .wr_cmp_lo(wr_cmp_lo), .wr_cmp_hi(wr_cmp_hi), .wr_data(wr_data),
        .cfg_word(cfg_word1), .cmp_word(cmp_word1), .irq_lines(irq_lines1),
        .cfg_err(cfg_err1));

    // R2/R3 vectors: config data, expected low config word, expected error
    localparam int NV = 5;
    localparam logic [31:0] TV_DATA [NV] = '{32'h0000_0004, 32'h0000_3E48,
        32'h0000_0002, 32'hFFFF_FFFD, 32'h0000_0000};
    localparam logic [31:0] TV_CFG  [NV] = '{32'h0000_0034, 32'h0000_3E78,
        32'h0000_0030, 32'h0000_3F7C, 32'h0000_0030};
    localparam logic        TV_ERR  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wcfg(input logic [31:0] d);
        wr_cfg = 1'b1; wr_data = d; cyc(); wr_cfg = 1'b0;
    endtask

    task automatic wlo(input logic [31:0] d);
        wr_cmp_lo = 1'b1; wr_data = d; cyc(); wr_cmp_lo = 1'b0;
    endtask

    task automatic whi(input logic [31:0] d);
        wr_cmp_hi = 1'b1; wr_data = d; cyc(); wr_cmp_hi = 1'b0;
    endtask

    task automatic tick(input logic [63:0] v);
        cnt_val = v; cnt_tick = 1'b1; cyc(); cnt_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cnt_val = '0; cnt_tick = 1'b0; glb_en = 1'b1;
        legacy_rt = 1'b0; wr_cfg = 1'b0; wr_cmp_lo = 1'b0; wr_cmp_hi = 1'b0;
        wr_data = '0;
        repeat (3) cyc();
        chk("R1 cfg", cfg_word, 64'h0000_0004_0000_0030);
        chk("R1 cmp", cmp_word, '1);
        chk("R1 irq", {32'h0, irq_lines}, 64'h0);
        chk("R1 err", {63'h0, cfg_err}, 64'h0);
        rst_n = 1'b1;
        cyc();

        // R2 / R3 vector walk
        for (int i = 0; i < NV; i++) begin
            wcfg(TV_DATA[i]);
            chk("R2 cfg", cfg_word, {32'h4, TV_CFG[i]});
            chk("R3 err", {63'h0, cfg_err}, {63'h0, TV_ERR[i]});
        end
        chk("R4 trunc", cmp_word, 64'h0000_0000_FFFF_FFFF);

        // R5 one-shot write, R7 match
        wcfg(32'h4);
        wlo(32'd50);
        chk("R5 oneshot", cmp_word, 64'd50);
        tick(64'd49);
        chk("R7 nomatch", {32'h0, irq_lines}, 64'h0);
        tick(64'd50);
        chk("R7 match", {32'h0, irq_lines}, 64'h1);
        cyc();
        chk("R7 single", {32'h0, irq_lines}, 64'h0);
        chk("R8 oneshot keep", cmp_word, 64'd50);

        // R12 gating
        glb_en = 1'b0;
        tick(64'd50);
        chk("R12 glb", {32'h0, irq_lines}, 64'h0);
        glb_en = 1'b1;
        wcfg(32'h0);
        tick(64'd50);
        chk("R12 chan", {32'h0, irq_lines}, 64'h0);

        // R11 routing
        wcfg(32'h0000_0A04);
        tick(64'd50);
        chk("R11 route", {32'h0, irq_lines}, 64'h20);
        legacy_rt = 1'b1;
        tick(64'd50);
        chk("R11 leg0", {32'h0, irq_lines}, 64'h1);
        chk("R11 leg1", {32'h0, irq_lines1}, 64'h100);
        legacy_rt = 1'b0;
        tick(64'd50);
        chk("R11 ch1 route", {32'h0, irq_lines1}, 64'h20);

        // R5 / R6 periodic load with set-value
        wcfg(32'h0000_004C);
        chk("R2 setv", cfg_word, 64'h0000_0004_0000_007C);
        wlo(32'd100);
        chk("R5 setv load", cmp_word, 64'd100);
        chk("R5 setv clr", cfg_word, 64'h0000_0004_0000_003C);
        wlo(32'd10);
        chk("R5 periodic keep", cmp_word, 64'd100);

        // R8 reload
        tick(64'd100);
        chk("R8 irq", {32'h0, irq_lines}, 64'h1);
        chk("R8 reload", cmp_word, 64'd110);
        tick(64'd110);
        chk("R8 reload2", cmp_word, 64'd120);

        // R9 catch-up
        tick(64'd120);
        chk("R9 match", cmp_word, 64'd130);
        cnt_val = 64'd155;
        cyc();
        chk("R9 step1", cmp_word, 64'd140);
        chk("R9 quiet1", {32'h0, irq_lines}, 64'h0);
        cyc();
        chk("R9 step2", cmp_word, 64'd150);
        cyc();
        chk("R9 step3", cmp_word, 64'd160);
        chk("R9 quiet3", {32'h0, irq_lines}, 64'h0);
        cyc();
        chk("R9 stop", cmp_word, 64'd160);

        // R6 64-bit period upper half
        wcfg(32'h0000_000C);
        whi(32'hFFFF_FFFF);
        chk("R6 hi keep cmp", cmp_word, 64'd160);
        tick(64'd160);
        chk("R6 hi period", cmp_word, 64'h7FFF_FFFF_0000_00AA);

        // R4 truncation, R6 31-bit period, R8 modular add
        wcfg(32'h0000_010C);
        chk("R4 trunc2", cmp_word, 64'h0000_0000_0000_00AA);
        wlo(32'hFFFF_FFFF);
        chk("R6 lo keep cmp", cmp_word, 64'hAA);
        tick(64'hAA);
        chk("R6 31bit", cmp_word, 64'h8000_00A9);
        tick(64'h8000_00A9);
        chk("R8 wrap add", cmp_word, 64'hA8);

        // R10 wrap in 32-bit one-shot
        wcfg(32'h0000_0104);
        tick(64'h0000_0000_FFFF_FFFF);
        chk("R10 prewrap", {32'h0, irq_lines}, 64'h0);
        tick(64'h0000_0001_0000_0000);
        chk("R10 wrap", {32'h0, irq_lines}, 64'h1);
        tick(64'h0000_0001_0000_0001);
        chk("R10 after", {32'h0, irq_lines}, 64'h0);
        tick(64'h0000_0001_0000_00A8);
        chk("R7 m32 match", {32'h0, irq_lines}, 64'h1);
        tick(64'h0000_0002_0000_0000);
        chk("R10 disarmed", {32'h0, irq_lines}, 64'h0);
        wlo(32'hA8);
        tick(64'h0000_0003_0000_0000);
        chk("R10 rearm", {32'h0, irq_lines}, 64'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule